// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM with Semaphore Flags

This block models a shared memory that two independent ports, left and right, can reach in the same clock cycle. Each port has active-low controls: chip select, read/write, output enable, a per-lane byte-select vector and semaphore select. It also has an address, a write-data bus, a read-data bus with a per-lane valid vector, and an error flag. In each cycle each port's control combination is decoded into exactly one action: idle, a memory read or write on the selected byte lanes, a read or write of one bit in a small bank of semaphore flags, or a rejected illegal combination.

Read data, lane-valid bits and the error flag are registered. They appear one clock after the access. The memory is read-first, so a read returns the word as it was before any write in the same cycle. In master mode, two memory accesses to the same address in the same cycle are arbitrated. The left port always proceeds. The right port is marked busy one cycle later and its write is dropped. In slave mode the block takes a busy input per port from outside, and that input blocks the port's memory write.

The semaphore bank gives two agents a cheap way to claim a shared resource. A flag reads 1 when free. The owner writes 0 to claim it and writes 1 to release it.

Top module: `twin_port_lane_ram`

## Requirements
- R1: A port with chip select high and semaphore select high, or with chip select low, semaphore select high and every byte select high, does nothing. It writes no memory, its valid vector is 0 and its error flag is 0 one clock later.
- R2: A memory write (chip select low, semaphore select high, read/write low) writes lane k, bits 8k+7..8k, only where byte select bit k is low. Bit 1 is the upper lane (15..8) and bit 0 the lower lane (7..0). Unselected lanes keep their contents.
- R3: A memory read (chip select low, semaphore select high, read/write high, output enable low, some byte select low) gives the word one clock later. The valid vector equals the inverted byte selects, and data bits of lanes that are not valid read 0.
- R4: While output enable is high the port's valid vector is 0 one clock later, whatever the other controls are.
- R5: Semaphore select low with chip select high reaches flag number addr[2:0]; the upper address bits are ignored. A write (read/write low) stores data bit 0. A read (read/write high, output enable low) returns the flag in bit 0 one clock later, with all other bits 0 and valid vector all ones. All flags reset to 1.
- R6: Chip select low and semaphore select low together with any byte select low raises the error flag one clock later, writes neither memory nor flags, and gives valid vector 0.
- R7: With master mode high, if both ports make a memory access to the same address in the same cycle, right busy is high one clock later and the right port's write is dropped. The left port's access proceeds and left busy stays low.
- R8: With master mode low, both busy outputs are low. A high busy input on a port drops that port's memory write in that cycle.
- R9: When one port writes an address and the other port reads it in the same cycle, the reader gets the word as it was before the write.
- R10: After synchronous reset, both valid vectors, both error flags and both busy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1: arbitrate collisions internally; 0: obey busy inputs |
| l_ce_n | input | 1 | Left memory chip select, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_bs_n | input | LANES | Left byte selects, active low, bit k for lane k |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | LANE_W*LANES | Left write data |
| l_dout | output | LANE_W*LANES | Left read data, invalid lanes zero |
| l_dvld | output | LANES | Left per-lane read valid |
| l_err | output | 1 | Left illegal combination flag |
| l_busy_i | input | 1 | Left external busy (slave mode) |
| l_busy_o | output | 1 | Left busy (never set, left has priority) |
| r_ce_n | input | 1 | Right memory chip select, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_bs_n | input | LANES | Right byte selects, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | LANE_W*LANES | Right write data |
| r_dout | output | LANE_W*LANES | Right read data, invalid lanes zero |
| r_dvld | output | LANES | Right per-lane read valid |
| r_err | output | 1 | Right illegal combination flag |
| r_busy_i | input | 1 | Right external busy (slave mode) |
| r_busy_o | output | 1 | Right busy, set after a same-address collision |

## Verification
The properties assume that every control input is a known 0 or 1 at each rising edge. They also assume that master mode does not change in the cycle a collision is being judged, because the busy output is checked against the mode of the previous cycle. The stimulus drives all inputs only on the falling edge, holds master mode constant across each test group, and keeps the right port to semaphore accesses while the left port sweeps every control combination. It never lets both ports write the same address in slave mode, because that outcome is left to the external arbiter.

// File: rtl/trp_pkg.sv
package trp_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_MEM_RD,
    ACT_MEM_WR,
    ACT_SEM_RD,
    ACT_SEM_WR,
    ACT_BAD
  } trp_act_e;

  localparam int unsigned NPORT = 2;
endpackage

// File: rtl/trp_decode.sv
module trp_decode
  import trp_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             ce_n,
  input  logic             rw_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] bs_n,
  input  logic             sem_n,
  output trp_act_e         act
);
  logic any_lane;
  assign any_lane = ~&bs_n;

  always_comb begin
    act = ACT_IDLE;
    if (!ce_n && !sem_n) begin
      act = any_lane ? ACT_BAD : ACT_IDLE;
    end else if (!sem_n) begin
      if (!rw_n)      act = ACT_SEM_WR;
      else if (!oe_n) act = ACT_SEM_RD;
    end else if (!ce_n && any_lane) begin
      if (!rw_n)      act = ACT_MEM_WR;
      else if (!oe_n) act = ACT_MEM_RD;
    end
  end
endmodule

// File: rtl/trp_lane_ram.sv
module trp_lane_ram #(
  parameter int AW     = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [AW-1:0]           a_addr,
  input  logic [LANES-1:0]        a_we,
  input  logic [LANES*LANE_W-1:0] a_din,
  output logic [LANES*LANE_W-1:0] a_q,
  input  logic [AW-1:0]           b_addr,
  input  logic [LANES-1:0]        b_we,
  input  logic [LANES*LANE_W-1:0] b_din,
  output logic [LANES*LANE_W-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] qa, qb;

    // read-first: both reads see the contents before this edge's writes;
    // port A is written last so it prevails on a shared address
    always_ff @(posedge clk) begin
      qa <= cells[a_addr];
      qb <= cells[b_addr];
      if (b_we[g]) cells[b_addr] <= b_din[g*LANE_W +: LANE_W];
      if (a_we[g]) cells[a_addr] <= a_din[g*LANE_W +: LANE_W];
    end

    assign a_q[g*LANE_W +: LANE_W] = qa;
    assign b_q[g*LANE_W +: LANE_W] = qb;
  end
endmodule

// File: rtl/trp_sem_bank.sv
module trp_sem_bank #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [IW-1:0] a_idx,
  input  logic          a_bit,
  input  logic          b_we,
  input  logic [IW-1:0] b_idx,
  input  logic          b_bit,
  output logic          a_q,
  output logic          b_q
);
  localparam int N = 1 << IW;
  logic [N-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '1;
      a_q   <= 1'b1;
      b_q   <= 1'b1;
    end else begin
      a_q <= flags[a_idx];
      b_q <= flags[b_idx];
      if (b_we) flags[b_idx] <= b_bit;
      if (a_we) flags[a_idx] <= a_bit;
    end
  end
endmodule

// File: rtl/twin_port_lane_ram.sv
module twin_port_lane_ram
  import trp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 2,
  parameter int SEM_IW = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    master_i,
  input  logic                    l_ce_n,
  input  logic                    l_rw_n,
  input  logic                    l_oe_n,
  input  logic [LANES-1:0]        l_bs_n,
  input  logic                    l_sem_n,
  input  logic [ADDR_W-1:0]       l_addr,
  input  logic [LANE_W*LANES-1:0] l_din,
  output logic [LANE_W*LANES-1:0] l_dout,
  output logic [LANES-1:0]        l_dvld,
  output logic                    l_err,
  input  logic                    l_busy_i,
  output logic                    l_busy_o,
  input  logic                    r_ce_n,
  input  logic                    r_rw_n,
  input  logic                    r_oe_n,
  input  logic [LANES-1:0]        r_bs_n,
  input  logic                    r_sem_n,
  input  logic [ADDR_W-1:0]       r_addr,
  input  logic [LANE_W*LANES-1:0] r_din,
  output logic [LANE_W*LANES-1:0] r_dout,
  output logic [LANES-1:0]        r_dvld,
  output logic                    r_err,
  input  logic                    r_busy_i,
  output logic                    r_busy_o
);
  localparam int DW = LANE_W * LANES;
  localparam int NP = NPORT;

  // index 0 = left, 1 = right
  logic              ce_n [NP];
  logic              rw_n [NP];
  logic              oe_n [NP];
  logic              sem_n [NP];
  logic              busy_in [NP];
  logic [LANES-1:0]  bs_n [NP];
  logic [ADDR_W-1:0] addr [NP];
  logic [DW-1:0]     din [NP];
  logic [DW-1:0]     dout [NP];
  logic [DW-1:0]     ram_q [NP];
  logic [LANES-1:0]  dvld [NP];
  logic [LANES-1:0]  we [NP];
  logic              err [NP];
  logic              is_mem [NP];
  logic              lose [NP];
  logic              sem_we [NP];
  logic              flag_q [NP];
  trp_act_e          act [NP];
  logic              hit;
  logic              busy_q;

  assign ce_n[0] = l_ce_n;    assign ce_n[1] = r_ce_n;
  assign rw_n[0] = l_rw_n;    assign rw_n[1] = r_rw_n;
  assign oe_n[0] = l_oe_n;    assign oe_n[1] = r_oe_n;
  assign sem_n[0] = l_sem_n;  assign sem_n[1] = r_sem_n;
  assign bs_n[0] = l_bs_n;    assign bs_n[1] = r_bs_n;
  assign addr[0] = l_addr;    assign addr[1] = r_addr;
  assign din[0] = l_din;      assign din[1] = r_din;
  assign busy_in[0] = l_busy_i;
  assign busy_in[1] = r_busy_i;

  assign hit = is_mem[0] && is_mem[1] && (addr[0] == addr[1]);

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [LANES-1:0] vld_q;
    logic             sem_sel_q;
    logic             err_q;
    logic [DW-1:0]    mask;

    trp_decode #(.LANES(LANES)) u_dec (
      .ce_n (ce_n[p]),
      .rw_n (rw_n[p]),
      .oe_n (oe_n[p]),
      .bs_n (bs_n[p]),
      .sem_n(sem_n[p]),
      .act  (act[p])
    );

    assign is_mem[p] = (act[p] == ACT_MEM_RD) || (act[p] == ACT_MEM_WR);

    // left has fixed priority in master mode
    if (p == 0) begin : g_winner
      assign lose[p] = 1'b0;
    end else begin : g_loser
      assign lose[p] = master_i && hit;
    end

    assign we[p] = ((act[p] == ACT_MEM_WR) && !lose[p] && !(!master_i && busy_in[p]))
                   ? ~bs_n[p] : '0;
    assign sem_we[p] = (act[p] == ACT_SEM_WR);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q     <= '0;
        sem_sel_q <= 1'b0;
        err_q     <= 1'b0;
      end else begin
        vld_q     <= (act[p] == ACT_MEM_RD) ? ~bs_n[p] : '0;
        sem_sel_q <= (act[p] == ACT_SEM_RD);
        err_q     <= (act[p] == ACT_BAD);
      end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_mask
      assign mask[g*LANE_W +: LANE_W] = {LANE_W{vld_q[g]}};
    end

    assign dout[p] = sem_sel_q ? {{(DW-1){1'b0}}, flag_q[p]} : (ram_q[p] & mask);
    assign dvld[p] = sem_sel_q ? '1 : vld_q;
    assign err[p]  = err_q;
  end

  trp_lane_ram #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk   (clk),
    .a_addr(addr[0]), .a_we(we[0]), .a_din(din[0]), .a_q(ram_q[0]),
    .b_addr(addr[1]), .b_we(we[1]), .b_din(din[1]), .b_q(ram_q[1])
  );

  trp_sem_bank #(.IW(SEM_IW)) u_sem (
    .clk  (clk),
    .rst  (rst),
    .a_we (sem_we[0]), .a_idx(addr[0][SEM_IW-1:0]), .a_bit(din[0][0]),
    .b_we (sem_we[1]), .b_idx(addr[1][SEM_IW-1:0]), .b_bit(din[1][0]),
    .a_q  (flag_q[0]),
    .b_q  (flag_q[1])
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= master_i && hit;
  end

  assign l_dout   = dout[0];
  assign l_dvld   = dvld[0];
  assign l_err    = err[0];
  assign l_busy_o = 1'b0;
  assign r_dout   = dout[1];
  assign r_dvld   = dvld[1];
  assign r_err    = err[1];
  assign r_busy_o = busy_q;
endmodule

// File: rtl/twin_port_lane_ram_chk.sv
module twin_port_lane_ram_chk #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    master_i,
  input logic                    l_ce_n,
  input logic                    l_rw_n,
  input logic                    l_oe_n,
  input logic [LANES-1:0]        l_bs_n,
  input logic                    l_sem_n,
  input logic [ADDR_W-1:0]       l_addr,
  input logic [LANE_W*LANES-1:0] l_dout,
  input logic [LANES-1:0]        l_dvld,
  input logic                    l_err,
  input logic                    l_busy_o,
  input logic                    r_ce_n,
  input logic                    r_rw_n,
  input logic                    r_oe_n,
  input logic [LANES-1:0]        r_bs_n,
  input logic                    r_sem_n,
  input logic [ADDR_W-1:0]       r_addr,
  input logic [LANE_W*LANES-1:0] r_dout,
  input logic [LANES-1:0]        r_dvld,
  input logic                    r_err,
  input logic                    r_busy_o
);
  localparam int DW = LANE_W * LANES;

  p_deselect_r1: assert property (@(posedge clk) disable iff (rst)
    (l_ce_n && l_sem_n) |=> (l_dvld == '0 && !l_err));

  p_read_lanes_r3: assert property (@(posedge clk) disable iff (rst)
    (!l_ce_n && l_sem_n && l_rw_n && !l_oe_n && !(&l_bs_n)) |=> (l_dvld == ~$past(l_bs_n)));

  p_oe_off_l_r4: assert property (@(posedge clk) disable iff (rst)
    l_oe_n |=> (l_dvld == '0));

  p_oe_off_r_r4: assert property (@(posedge clk) disable iff (rst)
    r_oe_n |=> (r_dvld == '0));

  p_sem_read_r5: assert property (@(posedge clk) disable iff (rst)
    (r_ce_n && !r_sem_n && r_rw_n && !r_oe_n) |=> (r_dvld == '1 && r_dout[DW-1:1] == '0));

  p_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    (!l_ce_n && !l_sem_n && !(&l_bs_n)) |=> (l_err && l_dvld == '0));

  p_collide_r7: assert property (@(posedge clk) disable iff (rst)
    (master_i && !l_ce_n && l_sem_n && !(&l_bs_n) && (!l_rw_n || !l_oe_n) &&
     !r_ce_n && r_sem_n && !(&r_bs_n) && (!r_rw_n || !r_oe_n) && l_addr == r_addr)
    |=> (r_busy_o && !l_busy_o));

  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !master_i |=> (!r_busy_o && !l_busy_o));

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (l_dvld == '0 && r_dvld == '0 && !l_err && !r_err && !r_busy_o && !l_busy_o));
endmodule

bind twin_port_lane_ram twin_port_lane_ram_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (
  .clk(clk), .rst(rst), .master_i(master_i),
  .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_bs_n(l_bs_n),
  .l_sem_n(l_sem_n), .l_addr(l_addr), .l_dout(l_dout), .l_dvld(l_dvld),
  .l_err(l_err), .l_busy_o(l_busy_o),
  .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_bs_n(r_bs_n),
  .r_sem_n(r_sem_n), .r_addr(r_addr), .r_dout(r_dout), .r_dvld(r_dvld),
  .r_err(r_err), .r_busy_o(r_busy_o)
);

// File: tb/twin_port_lane_ram_test.sv
module twin_port_lane_ram_test;
  localparam int AW = 6;
  localparam int NW = 1 << AW;

  // control word {ce_n, rw_n, oe_n, ub_n, lb_n, sem_n}
  localparam logic [5:0] C_IDLE    = 6'b111111;
  localparam logic [5:0] C_WR_BOTH = 6'b001001;
  localparam logic [5:0] C_WR_UP   = 6'b001011;
  localparam logic [5:0] C_WR_LO   = 6'b001101;
  localparam logic [5:0] C_RD_BOTH = 6'b010001;
  localparam logic [5:0] C_RD_UP   = 6'b010011;
  localparam logic [5:0] C_RD_LO   = 6'b010101;
  localparam logic [5:0] C_SEM_RD  = 6'b110110;
  localparam logic [5:0] C_SEM_WR  = 6'b101110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_i = 1'b1;
  logic l_ce_n, l_rw_n, l_oe_n, l_sem_n, l_busy_i, l_err, l_busy_o;
  logic r_ce_n, r_rw_n, r_oe_n, r_sem_n, r_busy_i, r_err, r_busy_o;
  logic [1:0]    l_bs_n, r_bs_n, l_dvld, r_dvld;
  logic [AW-1:0] l_addr, r_addr;
  logic [15:0]   l_din, r_din, l_dout, r_dout;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_mem [NW];
  logic        m_flag [8];

  always #4 clk = ~clk;

  twin_port_lane_ram #(.ADDR_W(AW), .LANE_W(8), .LANES(2), .SEM_IW(3)) uut (
    .clk(clk), .rst(rst), .master_i(master_i),
    .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_bs_n(l_bs_n),
    .l_sem_n(l_sem_n), .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
    .l_dvld(l_dvld), .l_err(l_err), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o),
    .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_bs_n(r_bs_n),
    .r_sem_n(r_sem_n), .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout),
    .r_dvld(r_dvld), .r_err(r_err), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setl(input logic [5:0] c, input logic [AW-1:0] a, input logic [15:0] d);
    {l_ce_n, l_rw_n, l_oe_n, l_bs_n, l_sem_n} = c;
    l_addr = a;
    l_din  = d;
  endtask

  task automatic setr(input logic [5:0] c, input logic [AW-1:0] a, input logic [15:0] d);
    {r_ce_n, r_rw_n, r_oe_n, r_bs_n, r_sem_n} = c;
    r_addr = a;
    r_din  = d;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] v);
    return {{8{v[1]}}, {8{v[0]}}};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [1:0] v,
                                        input logic [15:0] d);
    return (old & ~lane_mask(v)) | (d & lane_mask(v));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    l_busy_i = 1'b0;
    r_busy_i = 1'b0;
    setl(C_IDLE, '0, '0);
    setr(C_IDLE, '0, '0);
    for (int i = 0; i < 8; i++) m_flag[i] = 1'b1;
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    // R10 reset state
    chk("R10 l_dvld", 32'(l_dvld), 0);
    chk("R10 r_dvld", 32'(r_dvld), 0);
    chk("R10 errs", 32'({l_err, r_err}), 0);
    chk("R10 busy", 32'({l_busy_o, r_busy_o}), 0);

    // R5 flags reset to 1
    for (int i = 0; i < 8; i++) begin
      setr(C_SEM_RD, AW'(i), '0);
      tick();
      chk("R5 reset flag", 32'({r_dvld, r_dout}), 32'({2'b11, 16'h0001}));
    end
    setr(C_IDLE, '0, '0);

    // R2 fill all words through the left port
    for (int a = 0; a < NW; a++) begin
      m_mem[a] = 16'(a * 16'h0123) ^ 16'h5a5a;
      setl(C_WR_BOTH, AW'(a), m_mem[a]);
      tick();
    end

    // R3 read sweep through the right port with rotating lane choice
    for (int a = 0; a < NW; a++) begin
      logic [5:0] c;
      logic [1:0] v;
      c = (a % 3 == 0) ? C_RD_UP : ((a % 3 == 1) ? C_RD_LO : C_RD_BOTH);
      v = ~c[2:1];
      setl(C_IDLE, '0, '0);
      setr(c, AW'(a), 16'hffff);
      tick();
      chk("R3 lanes valid", 32'(r_dvld), 32'(v));
      chk("R3 read data", 32'(r_dout), 32'(m_mem[a] & lane_mask(v)));
    end
    setr(C_IDLE, '0, '0);

    // R2 single-lane writes, then full readback
    for (int a = 0; a < NW; a++) begin
      logic [15:0] d;
      d = ~16'(a * 16'h0707);
      if (a % 2 == 0) begin
        setl(C_WR_UP, AW'(a), d);
        m_mem[a] = merge(m_mem[a], 2'b10, d);
      end else begin
        setl(C_WR_LO, AW'(a), d);
        m_mem[a] = merge(m_mem[a], 2'b01, d);
      end
      tick();
    end
    for (int a = 0; a < NW; a++) begin
      setl(C_RD_BOTH, AW'(a), '0);
      tick();
      chk("R2 lane write readback", 32'(l_dout), 32'(m_mem[a]));
    end

    // R1 R4 R5 R6: every left control combination at address 5
    for (int k = 0; k < 64; k++) begin
      logic [5:0]  c;
      logic [15:0] d, exp_d;
      logic [1:0]  exp_v, sel;
      logic        bad, semacc, memacc, rd;
      c = 6'(k);
      d = 16'(k * 16'h0101) ^ 16'h3c3c;
      sel    = ~c[2:1];
      bad    = !c[5] && !c[0] && (sel != 2'b00);
      semacc = c[5] && !c[0];
      memacc = !c[5] && c[0] && (sel != 2'b00);
      rd     = c[4] && !c[3];
      exp_v  = 2'b00;
      exp_d  = 16'h0000;
      if (semacc && rd) begin
        exp_v = 2'b11;
        exp_d = {15'b0, m_flag[5]};
      end else if (memacc && rd) begin
        exp_v = sel;
        exp_d = m_mem[5] & lane_mask(sel);
      end
      setl(c, 6'd5, d);
      setr(C_IDLE, '0, '0);
      tick();
      chk("R6 error flag", 32'(l_err), 32'(bad));
      chk("R1 R4 valid lanes", 32'(l_dvld), 32'(exp_v));
      chk("R5 R3 data", 32'(l_dout), 32'(exp_d));
      if (semacc && !c[4]) m_flag[5] = d[0];
      if (memacc && !c[4]) m_mem[5] = merge(m_mem[5], sel, d);
      // state that the combination might have touched
      setl(C_RD_BOTH, 6'd5, '0);
      setr(C_SEM_RD, 6'd5, '0);
      tick();
      chk("R1 R6 word unchanged or written", 32'(l_dout), 32'(m_mem[5]));
      chk("R5 R6 flag", 32'(r_dout), 32'({15'b0, m_flag[5]}));
    end

    // R5 flag writes with upper address bits set, readback via the other port
    for (int i = 0; i < 8; i++) begin
      m_flag[i] = ~i[0];
      setr(C_IDLE, '0, '0);
      setl(C_SEM_WR, AW'(i + 8), 16'hfffe | 16'(m_flag[i]));
      tick();
    end
    for (int i = 0; i < 8; i++) begin
      setl(C_IDLE, '0, '0);
      setr(C_SEM_RD, AW'(i), '0);
      tick();
      chk("R5 flag readback", 32'(r_dout), 32'({15'b0, m_flag[i]}));
    end

    // R7 same-address writes, left wins
    setl(C_WR_BOTH, 6'd10, 16'h1111);
    setr(C_WR_BOTH, 6'd10, 16'h2222);
    tick();
    m_mem[10] = 16'h1111;
    chk("R7 right busy", 32'(r_busy_o), 1);
    chk("R7 left not busy", 32'(l_busy_o), 0);
    setl(C_RD_BOTH, 6'd10, '0);
    setr(C_IDLE, '0, '0);
    tick();
    chk("R7 left value kept", 32'(l_dout), 32'(m_mem[10]));
    chk("R7 busy clears", 32'(r_busy_o), 0);

    // R7 distinct addresses: both writes land, no busy
    setl(C_WR_BOTH, 6'd11, 16'haaaa);
    setr(C_WR_BOTH, 6'd12, 16'hbbbb);
    tick();
    m_mem[11] = 16'haaaa;
    m_mem[12] = 16'hbbbb;
    chk("R7 no busy on distinct", 32'(r_busy_o), 0);
    setl(C_RD_BOTH, 6'd12, '0);
    setr(C_RD_BOTH, 6'd11, '0);
    tick();
    chk("R7 left reads right write", 32'(l_dout), 32'(m_mem[12]));
    chk("R7 right reads left write", 32'(r_dout), 32'(m_mem[11]));

    // R9 left write, right read same word: old data
    setl(C_WR_BOTH, 6'd13, 16'hcccc);
    setr(C_RD_BOTH, 6'd13, '0);
    tick();
    chk("R9 right gets old", 32'(r_dout), 32'(m_mem[13]));
    chk("R7 busy on read collision", 32'(r_busy_o), 1);
    m_mem[13] = 16'hcccc;
    setl(C_IDLE, '0, '0);
    tick();
    chk("R9 new data after", 32'(r_dout), 32'(m_mem[13]));

    // R9 R7 right write into left read: old data, write dropped
    setl(C_RD_BOTH, 6'd14, '0);
    setr(C_WR_BOTH, 6'd14, 16'hdddd);
    tick();
    chk("R9 left gets old", 32'(l_dout), 32'(m_mem[14]));
    setr(C_IDLE, '0, '0);
    tick();
    chk("R7 dropped right write", 32'(l_dout), 32'(m_mem[14]));

    // R8 slave mode
    master_i = 1'b0;
    setl(C_RD_BOTH, 6'd15, '0);
    setr(C_RD_BOTH, 6'd15, '0);
    tick();
    chk("R8 no busy in slave", 32'({l_busy_o, r_busy_o}), 0);
    setl(C_IDLE, '0, '0);
    r_busy_i = 1'b1;
    setr(C_WR_BOTH, 6'd16, 16'heeee);
    tick();
    r_busy_i = 1'b0;
    l_busy_i = 1'b1;
    setl(C_WR_BOTH, 6'd17, 16'h1234);
    setr(C_RD_BOTH, 6'd16, '0);
    tick();
    chk("R8 right write blocked", 32'(r_dout), 32'(m_mem[16]));
    l_busy_i = 1'b0;
    setl(C_IDLE, '0, '0);
    setr(C_RD_BOTH, 6'd17, '0);
    tick();
    chk("R8 left write blocked", 32'(r_dout), 32'(m_mem[17]));
    setr(C_WR_BOTH, 6'd16, 16'heeee);
    tick();
    m_mem[16] = 16'heeee;
    setr(C_RD_BOTH, 6'd16, '0);
    tick();
    chk("R8 write when not busy", 32'(r_dout), 32'(m_mem[16]));

    summary();
    $finish;
  end
endmodule